// File: doc/BRIEF.md
# Register-Mapped Random Word Source

This peripheral supplies 32-bit pseudo-random words to software through a small register bus. Two linear feedback shift registers of unequal length step on every clock from the moment reset is released, and their states are combined into a word. Software can stir extra data into both registers by writing the entropy register. Generated words are queued in a short FIFO, and software takes them one at a time by reading the output register.

Words enter the FIFO only after software has set the start bit in the control register. The push timer is a two-state controller. In `CTL_IDLE`, nothing is pushed and the cycle counter is held at zero. A control write with the start bit set takes the *start* transition into `CTL_RUN`. The controller stays in `CTL_RUN` until reset. In `CTL_RUN`, one word is offered to the FIFO every `PUSH_INTERVAL` cycles (256 by default). An offer that finds the FIFO full is thrown away, so the queue stays as full as it can.

Each bus access takes one cycle. `bus_rdata` is combinational from the address. Any side effect of a read (a pop or a flag clear) takes place at the clock edge that closes that access.

Top module: `rndw_periph`

## Requirements
- R1: After reset, the control register (byte offset 0x0) reads 0, the status register (0x4) reads 0 and the FIFO is empty.
- R2: The generator steps from reset even while the start bit is clear, and no word enters the FIFO until the start bit has been set.
- R3: Writing control with bit 0 = 1 sets the start bit, which then reads back as bit 0 and stays set until reset. Later control writes, whether with 0 or 1, neither clear it nor restart the push timer.
- R4: The first push is offered `PUSH_INTERVAL` clock edges after the edge that set the start bit. Further pushes follow every `PUSH_INTERVAL` edges.
- R5: A push offered while the FIFO holds `FIFO_DEPTH` words is dropped. A pop in the same cycle does not make room for it.
- R6: Reading the output register (0xC) returns the oldest queued word and removes it from the FIFO. Words leave in the order they were pushed.
- R7: Reading the output register while the FIFO is empty returns 0 and sets the sticky underflow flag.
- R8: Status bits [7:4] hold the FIFO level, bit 1 is set exactly when the FIFO is full, and bit 0 is the underflow flag. A status read returns the flag and then clears it. All other status bits read 0.
- R9: Register A is 32 bits wide and shifts left, taking in a[31]^a[21]^a[1]^a[0]. After reset it holds 0xACE12461. Register B is 31 bits wide and shifts left, taking in b[30]^b[27]. After reset it holds 0x2B3C5D71. A pushed word is A ^ {B,1'b0}, using the state before the push edge.
- R10: A write to the entropy register (0x8) XORs the data into A's stepped value and XORs data[31:1] into B's stepped value. A register whose result would be all zeros is loaded with its reset value instead. The entropy register reads 0. Writes to status or output have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `PUSH_INTERVAL` = 16. This short interval lets the FIFO fill and overflow many times within a few thousand cycles, and the random read traffic keeps the queue moving between empty, partly full and full. The bench also chooses entropy values from its own model of the two registers so that each register's result would be exactly zero. This drives both zero-state guards, a case that random data would almost never reach.

// File: rtl/rndw_pkg.sv
package rndw_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ENT  = 2'd2,
        REG_OUT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    localparam int            LFSR_A_W    = 32;
    localparam logic [31:0]   LFSR_A_TAPS = 32'h8020_0003;
    localparam logic [31:0]   LFSR_A_SEED = 32'hACE1_2461;
    localparam int            LFSR_B_W    = 31;
    localparam logic [30:0]   LFSR_B_TAPS = 31'h4800_0000;
    localparam logic [30:0]   LFSR_B_SEED = 31'h2B3C_5D71;

    localparam int CTL_GO_BIT  = 0;
    localparam int ST_UND_BIT  = 0;
    localparam int ST_FULL_BIT = 1;
    localparam int ST_LVL_LSB  = 4;
    localparam int ST_LVL_W    = 4;

endpackage

// File: rtl/rndw_lfsr.sv
module rndw_lfsr #(
    parameter int           W    = 32,
    parameter logic [W-1:0] TAPS = '1,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mix_en,
    input  logic [W-1:0] mix_val,
    output logic [W-1:0] state_o
);

    logic [W-1:0] st_q;
    logic [W-1:0] stepped;
    logic [W-1:0] mixed;
    logic [W-1:0] st_d;

    always_comb begin
        stepped = {st_q[W-2:0], ^(st_q & TAPS)};
        mixed   = mix_en ? (stepped ^ mix_val) : stepped;
        // an all-zero state would lock up; fall back to the seed
        st_d    = (mixed == '0) ? SEED : mixed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/rndw_fifo.sv
module rndw_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push_i,
    input  logic [W-1:0]                     push_data_i,
    input  logic                             pop_i,
    output logic [W-1:0]                     head_o,
    output logic [$clog2(DEPTH+1)-1:0]       level_o,
    output logic                             full_o,
    output logic                             empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             do_push;
    logic             do_pop;

    assign full_o  = (level_q == LVL_W'(DEPTH));
    assign empty_o = (level_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
            if (do_push && !do_pop)      level_q <= level_q + 1'b1;
            else if (do_pop && !do_push) level_q <= level_q - 1'b1;
        end
    end

    assign head_o  = empty_o ? '0 : mem_q[rd_ptr_q];
    assign level_o = level_q;

endmodule

// File: rtl/rndw_ctrl.sv
module rndw_ctrl
    import rndw_pkg::*;
#(
    parameter int INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic go_o,
    output logic tick_o
);

    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == CNT_W'(INTERVAL - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: if (start_i) state_d = CTL_RUN;
            CTL_RUN:  state_d = CTL_RUN;
            default:  state_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q != CTL_RUN) cnt_q <= '0;
        else if (at_end)             cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        go_o   = 1'b0;
        tick_o = 1'b0;
        unique case (state_q)
            CTL_IDLE: ;
            CTL_RUN: begin
                go_o   = 1'b1;
                tick_o = at_end;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rndw_periph.sv
module rndw_periph
    import rndw_pkg::*;
#(
    parameter int FIFO_DEPTH    = 4,
    parameter int PUSH_INTERVAL = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              wr_ent;
    logic              rd_stat;
    logic              rd_out;
    logic              go;
    logic              tick;
    logic [31:0]       a_state;
    logic [30:0]       b_state;
    logic [31:0]       word;
    logic [31:0]       head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              fifo_empty;
    logic              und_q;
    logic [ST_LVL_W-1:0] lvl_field;
    logic [1:0]        unused_addr;

    assign unused_addr = bus_addr[1:0];
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_ctrl = bus_sel &&  bus_wr && (sel == REG_CTRL);
    assign wr_ent  = bus_sel &&  bus_wr && (sel == REG_ENT);
    assign rd_stat = bus_sel && !bus_wr && (sel == REG_STAT);
    assign rd_out  = bus_sel && !bus_wr && (sel == REG_OUT);

    rndw_ctrl #(.INTERVAL(PUSH_INTERVAL)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_ctrl && bus_wdata[CTL_GO_BIT]),
        .go_o    (go),
        .tick_o  (tick)
    );

    rndw_lfsr #(.W(LFSR_A_W), .TAPS(LFSR_A_TAPS), .SEED(LFSR_A_SEED)) lfsr_a_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mix_en  (wr_ent),
        .mix_val (bus_wdata),
        .state_o (a_state)
    );

    rndw_lfsr #(.W(LFSR_B_W), .TAPS(LFSR_B_TAPS), .SEED(LFSR_B_SEED)) lfsr_b_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mix_en  (wr_ent),
        .mix_val (bus_wdata[31:1]),
        .state_o (b_state)
    );

    assign word = a_state ^ {b_state, 1'b0};

    rndw_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (tick),
        .push_data_i (word),
        .pop_i       (rd_out),
        .head_o      (head),
        .level_o     (fifo_level),
        .full_o      (fifo_full),
        .empty_o     (fifo_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   und_q <= 1'b0;
        else if (rd_out && fifo_empty) und_q <= 1'b1;
        else if (rd_stat)             und_q <= 1'b0;
    end

    assign lvl_field = ST_LVL_W'(fifo_level);

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_CTRL: bus_rdata[CTL_GO_BIT] = go;
            REG_STAT: begin
                bus_rdata[ST_LVL_LSB +: ST_LVL_W] = lvl_field;
                bus_rdata[ST_FULL_BIT]            = fifo_full;
                bus_rdata[ST_UND_BIT]             = und_q;
            end
            REG_ENT:  bus_rdata = '0;
            REG_OUT:  bus_rdata = head;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rndw_periph_chk.sv
module rndw_periph_chk #(
    parameter int FIFO_DEPTH    = 4,
    parameter int PUSH_INTERVAL = 256
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           go,
    input logic                           tick,
    input logic                           pop_req,
    input logic                           stat_rd,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] level,
    input logic                           full,
    input logic                           underflow,
    input logic [31:0]                    lfsr_a,
    input logic [30:0]                    lfsr_b
);

    localparam int GW = $clog2(PUSH_INTERVAL) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           gap_q <= '0;
        else if (!go || tick) gap_q <= '0;
        else                  gap_q <= gap_q + 1'b1;
    end

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FIFO_DEPTH);

    a_r2_no_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (level <= $past(level)));

    a_r3_go_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> go);

    a_r4_push_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == GW'(PUSH_INTERVAL - 1)));

    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_req) |=> full);

    a_r6_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && level != 0 && !tick) |=> (level == $past(level) - 1'b1));

    a_r7_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && level == 0) |=> underflow);

    a_r8_underflow_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !pop_req) |=> !underflow);

    a_r10_nonzero_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_a != '0) && (lfsr_b != '0));

endmodule

bind rndw_periph rndw_periph_chk #(
    .FIFO_DEPTH    (FIFO_DEPTH),
    .PUSH_INTERVAL (PUSH_INTERVAL)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .tick      (tick),
    .pop_req   (rd_out),
    .stat_rd   (rd_stat),
    .level     (fifo_level),
    .full      (fifo_full),
    .underflow (und_q),
    .lfsr_a    (a_state),
    .lfsr_b    (b_state)
);

// File: tb/rndw_periph_tb.sv
module rndw_periph_tb_top;

    localparam int DEPTH = 4;
    localparam int N     = 16;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_ENT  = 4'h8;
    localparam logic [3:0] A_OUT  = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rndw_periph #(.FIFO_DEPTH(DEPTH), .PUSH_INTERVAL(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // ---- reference model, built from the requirement text ----
    logic [31:0] m_a;
    logic [30:0] m_b;
    logic        m_go;
    int          m_cnt;
    logic        m_und;
    logic [31:0] m_q [DEPTH];
    int          m_lvl;

    function automatic logic [31:0] step_a(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic [30:0] step_b(input logic [30:0] s);
        return {s[29:0], s[30] ^ s[27]};
    endfunction

    function automatic logic [31:0] m_expect(input logic [3:0] addr);
        logic [31:0] v;
        v = '0;
        case (addr[3:2])
            2'd0: v[0] = m_go;
            2'd1: begin
                v[7:4] = 4'(m_lvl);
                v[1]   = (m_lvl == DEPTH);
                v[0]   = m_und;
            end
            2'd2: v = '0;
            default: v = (m_lvl > 0) ? m_q[0] : 32'h0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 32'hACE1_2461; m_b = 31'h2B3C_5D71;
            m_go = 1'b0; m_cnt = 0; m_und = 1'b0; m_lvl = 0;
        end else begin
            logic [31:0] w;
            logic        tk, was_full, rd_o, rd_s, wr_c, wr_e;
            logic [31:0] na;
            logic [30:0] nb;
            w        = m_a ^ {m_b, 1'b0};
            tk       = m_go && (m_cnt == N - 1);
            was_full = (m_lvl == DEPTH);
            rd_o = bus_sel && !bus_wr && bus_addr[3:2] == 2'd3;
            rd_s = bus_sel && !bus_wr && bus_addr[3:2] == 2'd1;
            wr_c = bus_sel &&  bus_wr && bus_addr[3:2] == 2'd0;
            wr_e = bus_sel &&  bus_wr && bus_addr[3:2] == 2'd2;
            if (rd_o && m_lvl == 0) m_und = 1'b1;
            else if (rd_s)          m_und = 1'b0;
            if (rd_o && m_lvl > 0) begin
                for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
                m_lvl--;
            end
            if (tk && !was_full) begin
                m_q[m_lvl] = w;
                m_lvl++;
            end
            if (m_go) m_cnt = (m_cnt == N - 1) ? 0 : m_cnt + 1;
            if (wr_c && bus_wdata[0] && !m_go) begin
                m_go = 1'b1; m_cnt = 0;
            end
            na = step_a(m_a) ^ (wr_e ? bus_wdata : 32'h0);
            nb = step_b(m_b) ^ (wr_e ? bus_wdata[31:1] : 31'h0);
            m_a = (na == '0) ? 32'hACE1_2461 : na;
            m_b = (nb == '0) ? 31'h2B3C_5D71 : nb;
        end
    end

    // ---- bus tasks ----
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] addr, input string tag, output logic [31:0] got);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr; bus_wdata = '0;
        #2;
        got = bus_rdata;
        check(tag, got, m_expect(addr));
        @(posedge clk);
    endtask

    task automatic do_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        do_read(A_CTRL, "R1 ctrl after reset", v);  check("R1 ctrl zero", v, 32'h0);
        do_read(A_STAT, "R1 status after reset", v); check("R1 status zero", v, 32'h0);

        // R2 generator runs, nothing pushed without start bit
        idle(3 * N);
        do_read(A_STAT, "R2 no push before start", v); check("R2 level zero", v, 32'h0);

        // R7/R8 underflow behaviour
        do_read(A_OUT, "R7 empty read", v);   check("R7 empty returns zero", v, 32'h0);
        do_read(A_STAT, "R8 underflow seen", v); check("R8 underflow bit", v, 32'h1);
        do_read(A_STAT, "R8 underflow cleared", v); check("R8 cleared", v, 32'h0);

        // R10 entropy reads zero, writes to read-only registers ignored
        do_write(A_ENT, 32'h1234_5678);
        do_read(A_ENT, "R10 entropy reads zero", v); check("R10 entropy zero", v, 32'h0);
        do_write(A_STAT, 32'hFFFF_FFFF);
        do_write(A_OUT, 32'hFFFF_FFFF);
        do_read(A_STAT, "R10 status unaffected", v); check("R10 status still zero", v, 32'h0);

        // R3/R4 start and first push timing
        do_write(A_CTRL, 32'h1);
        for (int k = 0; k < N; k++) begin
            do_read(A_STAT, "R4 before first push", v);
            check("R4 level zero before interval", v, 32'h0);
        end
        do_read(A_STAT, "R4 first push", v); check("R4 one word after interval", v, 32'h10);
        do_read(A_CTRL, "R3 start bit set", v); check("R3 go reads one", v, 32'h1);
        do_write(A_CTRL, 32'h0);
        do_read(A_CTRL, "R3 start bit sticky", v); check("R3 go stays set", v, 32'h1);

        // R5 fill and overflow
        idle(6 * N);
        do_read(A_STAT, "R5 full status", v); check("R5 full level", v, 32'h42);
        // R6 drain in order (model supplies words, R9 formula)
        for (int k = 0; k < DEPTH; k++) do_read(A_OUT, "R6 R9 pop oldest", v);
        do_read(A_STAT, "R6 empty after drain", v);

        // R10 zero guard on register A, then on register B
        do_write(A_ENT, step_a(m_a));
        do_write(A_ENT, {step_b(m_b), 1'b0});
        idle(2 * N + 2);
        for (int k = 0; k < 3; k++) do_read(A_OUT, "R10 R9 words after zero guard", v);

        // random traffic
        for (int it = 0; it < 1500; it++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 35)      do_read(A_OUT,  "R6 R7 R9 random output read", v);
            else if (r < 50) do_read(A_STAT, "R5 R8 random status read", v);
            else if (r < 55) do_read(A_CTRL, "R3 random ctrl read", v);
            else if (r < 58) do_read(A_ENT,  "R10 random entropy read", v);
            else if (r < 68) do_write(A_ENT, $urandom);
            else if (r < 73) do_write(A_CTRL, $urandom);
            else if (r < 78) do_write($urandom_range(0, 1) ? A_STAT : A_OUT, $urandom);
            else if (r < 80) idle($urandom_range(N, 6 * N));
            else             idle(1);
        end

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule